// File: doc/BRIEF.md
# Dual-Port Address Pointer Register File

This block keeps the pointer state of an address generator: eight 16-bit pointer registers, each paired with its own 16-bit step (offset) register and 16-bit wrap-control (modifier) register. Two request ports can each present a register index and an indirect addressing mode in the same cycle. For each port the block produces the effective address, writes any updated pointer back at the next clock edge, and flags modes that take an extra instruction cycle.

The update arithmetic (linear, modulo or reverse-carry, as picked by the pointer's wrap-control register) is not computed here. Each port hands the pointer, the step and the wrap-control value to an external arithmetic block through a combinational port and takes back the result. A direct register port loads and reads any of the 24 registers for general-purpose use, and a load takes priority over a same-cycle pointer update.

The pointers form two banks, indexes 0-3 and 4-7 (index bit 2 selects the bank). A dual access, with both ports valid, must address one pointer in each bank and may use only the cheap modes; anything else is reported as illegal and changes nothing.

Top module: `agu_ptr_file`

## Requirements
- R1: After reset every pointer, step and wrap-control register reads 0xFFFF, and `illegal` and `extra_cycle` are low while no request is valid.
- R2: `rd_data` shows the register chosen by `rd_sel` (0 pointer, 1 step, 2 wrap-control) and `rd_idx` in the same cycle; a load with `wr_en` high writes `wr_data` to that register at the next rising edge, and `wr_sel` value 3 writes nothing.
- R3: For each port the arithmetic port carries the addressed pointer on `upd_base`, its own wrap-control register on `upd_mod`, a step of 1 for the by-one modes or the step register for the by-offset modes on `upd_step`, and `upd_sub` high for the decrementing modes.
- R4: Mode codes 1 (post-increment by 1), 2 (post-decrement by 1), 3 (post-increment by step) and 4 (post-decrement by step) output the old pointer as `ea` and store `upd_res` into the pointer at the next edge; the step register is unchanged.
- R5: Mode code 5 (indexed) outputs `upd_res` (pointer plus step) as `ea`, changes no register and raises `extra_cycle` for that port.
- R6: Mode code 6 (pre-decrement by 1) outputs `upd_res` as `ea`, stores it into the pointer at the next edge and raises `extra_cycle` for that port.
- R7: Mode code 0 (no update) outputs the pointer as `ea` and changes no register; `extra_cycle` stays low.
- R8: In a dual access, a port using mode 4, 5 or 6 makes `illegal` high; then neither port writes back and `extra_cycle` stays low.
- R9: A dual access whose two indexes share index bit 2 (same bank, including the same register) makes `illegal` high and writes nothing back.
- R10: Mode code 7 is reserved: a valid request with it makes `illegal` high and writes nothing back.
- R11: A load to a register in the same cycle as a pointer update of that register wins; the update of the pointer is lost, and an update that reads a step register being loaded uses its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 2 | Request valid, one bit per port |
| req_idx | input | 2x3 | Pointer index per port |
| req_mode | input | 2x3 | Addressing mode code per port |
| ea | output | 2x16 | Effective address per port |
| extra_cycle | output | 2 | Mode costs one extra cycle, per port |
| illegal | output | 1 | Request combination not allowed |
| upd_base | output | 2x16 | Pointer value to the arithmetic block |
| upd_step | output | 2x16 | Step amount to the arithmetic block |
| upd_mod | output | 2x16 | Wrap-control value to the arithmetic block |
| upd_sub | output | 2 | Subtract rather than add |
| upd_res | input | 2x16 | Result from the arithmetic block |
| wr_en | input | 1 | Register load enable |
| wr_sel | input | 2 | Load target kind: 0 pointer, 1 step, 2 wrap-control |
| wr_idx | input | 3 | Load target index |
| wr_data | input | 16 | Load data |
| rd_sel | input | 2 | Read kind: 0 pointer, 1 step, 2 wrap-control |
| rd_idx | input | 3 | Read index |
| rd_data | output | 16 | Read data |

## Verification
The hardest situation to reach is a rejected dual access that would otherwise have written two pointers, because from the ports it looks like nothing happened. The stimulus first loads distinct values into every pointer, then issues each forbidden mode pairing and each same-bank pairing on both ports at once, and reads back both addressed pointers afterwards to show they kept their values. The arithmetic block is modelled in the bench with modulo, reverse-carry and linear rules, so pointers with different wrap-control values prove that each port forwards its own pointer's settings.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AGU_AW    = 16;
    localparam int AGU_NREG  = 8;
    localparam int AGU_NPORT = 2;

    typedef enum logic [2:0] {
        MD_NONE = 3'd0,
        MD_INC1 = 3'd1,
        MD_DEC1 = 3'd2,
        MD_INCN = 3'd3,
        MD_DECN = 3'd4,
        MD_IDX  = 3'd5,
        MD_PRE  = 3'd6,
        MD_RSV  = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SEL_PTR = 2'd0,
        SEL_OFS = 2'd1,
        SEL_MOD = 2'd2,
        SEL_NIL = 2'd3
    } sel_e;

    typedef struct packed {
        logic ea_res;    // effective address comes from the arithmetic result
        logic wb;        // pointer is written back
        logic use_ofs;   // step is the offset register, else 1
        logic sub;       // decrementing mode
        logic costly;    // mode takes an extra cycle
        logic dual_bad;  // not permitted in a dual access
        logic rsv;       // reserved code
    } mode_ctl_t;

endpackage

// File: rtl/agu_mode_dec.sv
module agu_mode_dec
    import agu_pkg::*;
(
    input  logic [2:0] mode,
    output mode_ctl_t  ctl
);

    always_comb begin
        ctl = '0;
        case (mode_e'(mode))
            MD_NONE: ;
            MD_INC1: ctl.wb = 1'b1;
            MD_DEC1: begin
                ctl.wb  = 1'b1;
                ctl.sub = 1'b1;
            end
            MD_INCN: begin
                ctl.wb      = 1'b1;
                ctl.use_ofs = 1'b1;
            end
            MD_DECN: begin
                ctl.wb       = 1'b1;
                ctl.use_ofs  = 1'b1;
                ctl.sub      = 1'b1;
                ctl.dual_bad = 1'b1;
            end
            MD_IDX: begin
                ctl.ea_res   = 1'b1;
                ctl.use_ofs  = 1'b1;
                ctl.costly   = 1'b1;
                ctl.dual_bad = 1'b1;
            end
            MD_PRE: begin
                ctl.ea_res   = 1'b1;
                ctl.wb       = 1'b1;
                ctl.sub      = 1'b1;
                ctl.costly   = 1'b1;
                ctl.dual_bad = 1'b1;
            end
            default: ctl.rsv = 1'b1;
        endcase
    end

endmodule

// File: rtl/agu_regbank.sv
module agu_regbank
    import agu_pkg::*;
#(
    parameter int AW    = AGU_AW,
    parameter int NREG  = AGU_NREG,
    parameter int NPORT = AGU_NPORT,
    localparam int IW   = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [IW-1:0]                wr_idx,
    input  logic [AW-1:0]                wr_data,
    input  logic [NPORT-1:0]             upd_en,
    input  logic [NPORT-1:0][IW-1:0]     upd_idx,
    input  logic [NPORT-1:0][AW-1:0]     upd_val,
    output logic [NREG-1:0][AW-1:0]      r_q,
    output logic [NREG-1:0][AW-1:0]      n_q,
    output logic [NREG-1:0][AW-1:0]      m_q
);

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] r;
        logic [NREG-1:0][AW-1:0] n;
        logic [NREG-1:0][AW-1:0] m;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPORT; p++) begin
            if (upd_en[p]) begin
                st_d.r[upd_idx[p]] = upd_val[p];
            end
        end
        // a load is applied last so it overrides a same-cycle update
        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_PTR: st_d.r[wr_idx] = wr_data;
                SEL_OFS: st_d.n[wr_idx] = wr_data;
                SEL_MOD: st_d.m[wr_idx] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_q = st_q.r;
    assign n_q = st_q.n;
    assign m_q = st_q.m;

endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file
    import agu_pkg::*;
#(
    parameter int AW   = AGU_AW,
    parameter int NREG = AGU_NREG,
    localparam int NPORT = AGU_NPORT,
    localparam int IW    = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_vld,
    input  logic [NPORT-1:0][IW-1:0]  req_idx,
    input  logic [NPORT-1:0][2:0]     req_mode,
    output logic [NPORT-1:0][AW-1:0]  ea,
    output logic [NPORT-1:0]          extra_cycle,
    output logic                      illegal,
    output logic [NPORT-1:0][AW-1:0]  upd_base,
    output logic [NPORT-1:0][AW-1:0]  upd_step,
    output logic [NPORT-1:0][AW-1:0]  upd_mod,
    output logic [NPORT-1:0]          upd_sub,
    input  logic [NPORT-1:0][AW-1:0]  upd_res,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [IW-1:0]             wr_idx,
    input  logic [AW-1:0]             wr_data,
    input  logic [1:0]                rd_sel,
    input  logic [IW-1:0]             rd_idx,
    output logic [AW-1:0]             rd_data
);

    localparam int BANK_BIT = IW - 1;

    logic [NREG-1:0][AW-1:0]  r_q, n_q, m_q;
    mode_ctl_t [NPORT-1:0]    ctl;
    logic [NPORT-1:0]         port_bad;
    logic [NPORT-1:0]         upd_en;
    logic                     dual;
    logic                     same_bank;

    assign dual      = &req_vld;
    assign same_bank = dual && (req_idx[0][BANK_BIT] == req_idx[1][BANK_BIT]);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        agu_mode_dec i_dec (
            .mode (req_mode[p]),
            .ctl  (ctl[p])
        );

        assign upd_base[p] = r_q[req_idx[p]];
        assign upd_mod[p]  = m_q[req_idx[p]];
        assign upd_step[p] = ctl[p].use_ofs ? n_q[req_idx[p]] : AW'(1);
        assign upd_sub[p]  = ctl[p].sub;
        assign ea[p]       = ctl[p].ea_res ? upd_res[p] : r_q[req_idx[p]];

        assign port_bad[p]    = req_vld[p] && (ctl[p].rsv || (dual && ctl[p].dual_bad));
        assign extra_cycle[p] = req_vld[p] && ctl[p].costly && !illegal;
        assign upd_en[p]      = req_vld[p] && ctl[p].wb && !illegal;
    end

    assign illegal = (|port_bad) || same_bank;

    agu_regbank #(
        .AW    (AW),
        .NREG  (NREG),
        .NPORT (NPORT)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_idx (req_idx),
        .upd_val (upd_res),
        .r_q     (r_q),
        .n_q     (n_q),
        .m_q     (m_q)
    );

    always_comb begin
        case (sel_e'(rd_sel))
            SEL_PTR: rd_data = r_q[rd_idx];
            SEL_OFS: rd_data = n_q[rd_idx];
            SEL_MOD: rd_data = m_q[rd_idx];
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/agu_ptr_file_chk.sv
module agu_ptr_file_chk #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               req_vld,
    input logic [1:0][IW-1:0]       req_idx,
    input logic [1:0][2:0]          req_mode,
    input logic [1:0][AW-1:0]       ea,
    input logic [1:0]               extra_cycle,
    input logic                     illegal,
    input logic [1:0][AW-1:0]       upd_res,
    input logic                     wr_en,
    input logic [1:0]               wr_sel,
    input logic [IW-1:0]            wr_idx,
    input logic [AW-1:0]            wr_data,
    input logic [NREG-1:0][AW-1:0]  r_q
);

    logic ld_hits0;
    assign ld_hits0 = wr_en && (wr_sel == 2'd0) && (wr_idx == req_idx[0]);

    AST_POST_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && !illegal && req_mode[0] inside {3'd1, 3'd2, 3'd3, 3'd4})
        |-> ea[0] == r_q[req_idx[0]]); // R4

    AST_POST_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && !illegal && !ld_hits0 && req_mode[0] inside {3'd1, 3'd2, 3'd3, 3'd4})
        |=> r_q[$past(req_idx[0])] == $past(upd_res[0])); // R4

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && !illegal && !wr_en && req_mode[0] == 3'd5)
        |=> r_q == $past(r_q)); // R5

    AST_EXTRA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        extra_cycle[0] |-> (req_vld[0] && req_mode[0] inside {3'd5, 3'd6})); // R6

    AST_DUAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_vld && req_mode[0] inside {3'd4, 3'd5, 3'd6}) |-> illegal); // R8

    AST_DUAL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_vld && req_idx[0][IW-1] == req_idx[1][IW-1]) |-> illegal); // R9

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !wr_en) |=> r_q == $past(r_q)); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> r_q[$past(wr_idx)] == $past(wr_data)); // R11

endmodule

bind agu_ptr_file agu_ptr_file_chk #(
    .AW   (AW),
    .NREG (NREG)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_idx     (req_idx),
    .req_mode    (req_mode),
    .ea          (ea),
    .extra_cycle (extra_cycle),
    .illegal     (illegal),
    .upd_res     (upd_res),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .r_q         (r_q)
);

// File: tb/test_agu_ptr_file.sv
module test_agu_ptr_file;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_vld = '0;
    logic [1:0][IW-1:0]   req_idx = '0;
    logic [1:0][2:0]      req_mode = '0;
    logic [1:0][AW-1:0]   ea;
    logic [1:0]           extra_cycle;
    logic                 illegal;
    logic [1:0][AW-1:0]   upd_base, upd_step, upd_mod;
    logic [1:0]           upd_sub;
    logic [1:0][AW-1:0]   upd_res;
    logic                 wr_en = 1'b0;
    logic [1:0]           wr_sel = '0;
    logic [IW-1:0]        wr_idx = '0;
    logic [AW-1:0]        wr_data = '0;
    logic [1:0]           rd_sel = '0;
    logic [IW-1:0]        rd_idx = '0;
    logic [AW-1:0]        rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [AW-1:0] mr [8];
    logic [AW-1:0] mn [8];
    logic [AW-1:0] mm [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_ptr_file i_agu_ptr_file (
        .clk, .rst_n, .req_vld, .req_idx, .req_mode, .ea, .extra_cycle, .illegal,
        .upd_base, .upd_step, .upd_mod, .upd_sub, .upd_res,
        .wr_en, .wr_sel, .wr_idx, .wr_data, .rd_sel, .rd_idx, .rd_data
    );

    function automatic logic [AW-1:0] brev(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
        return o;
    endfunction

    // external update arithmetic: linear, reverse-carry or modulo
    function automatic logic [AW-1:0] arith(input logic [AW-1:0] b, input logic [AW-1:0] s,
                                            input logic sub, input logic [AW-1:0] m);
        logic [AW-1:0] mask, lower, r;
        if (m == 16'h0000) begin
            return sub ? brev(brev(b) - brev(s)) : brev(brev(b) + brev(s));
        end else if (m <= 16'h7FFF) begin
            mask  = m | (m >> 1);
            mask  = mask | (mask >> 2);
            mask  = mask | (mask >> 4);
            mask  = mask | (mask >> 8);
            lower = b & ~mask;
            if (sub) begin
                r = b - s;
                if ({1'b0, b} < {1'b0, lower} + {1'b0, s}) r = r + m + 16'd1;
            end else begin
                r = b + s;
                if ({1'b0, b} + {1'b0, s} > {1'b0, lower} + {1'b0, m}) r = r - m - 16'd1;
            end
            return r;
        end
        return sub ? b - s : b + s;
    endfunction

    always_comb begin
        for (int p = 0; p < 2; p++)
            upd_res[p] = arith(upd_base[p], upd_step[p], upd_sub[p], upd_mod[p]);
    end

    task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] i, output logic [AW-1:0] v);
        rd_sel = s;
        rd_idx = i;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] i, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (s)
            2'd0: mr[i] = d;
            2'd1: mn[i] = d;
            2'd2: mm[i] = d;
            default: ;
        endcase
    endtask

    task automatic load_set(input logic [2:0] i, input logic [AW-1:0] r,
                            input logic [AW-1:0] n, input logic [AW-1:0] m);
        wr(2'd0, i, r);
        wr(2'd1, i, n);
        wr(2'd2, i, m);
    endtask

    task automatic preload();
        load_set(3'd0, 16'd75,   16'd15,  16'd20);   // modulo 21
        load_set(3'd1, 16'd3072, 16'd512, 16'd0);    // reverse carry
        load_set(3'd2, 16'd6,    16'd0,   16'd5);    // modulo 6, out of range
        load_set(3'd3, 16'd100,  16'd7,   16'hFFFF);
        load_set(3'd4, 16'h0000, 16'd3,   16'hFFFF);
        load_set(3'd5, 16'h7706, 16'd3,   16'hFFFF);
        load_set(3'd6, 16'h6000, 16'd4,   16'hFFFF);
        load_set(3'd7, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    // bench view of the mode codes
    function automatic logic m_wb(input logic [2:0] m);  return m inside {3'd1,3'd2,3'd3,3'd4,3'd6}; endfunction
    function automatic logic m_res(input logic [2:0] m); return m inside {3'd5,3'd6};               endfunction
    function automatic logic m_ofs(input logic [2:0] m); return m inside {3'd3,3'd4,3'd5};          endfunction
    function automatic logic m_sub(input logic [2:0] m); return m inside {3'd2,3'd4,3'd6};          endfunction

    typedef struct packed {
        logic [3:0] rq;
        logic [1:0] vld;
        logic [2:0] i0;
        logic [2:0] md0;
        logic [2:0] i1;
        logic [2:0] md1;
        logic       ill;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  2'b01, 3'd0, 3'd3, 3'd0, 3'd0, 1'b0},  // R4 modulo wrap
        '{4'd4,  2'b01, 3'd1, 3'd3, 3'd0, 3'd0, 1'b0},  // R4 reverse carry
        '{4'd4,  2'b01, 3'd1, 3'd3, 3'd0, 3'd0, 1'b0},  // R4
        '{4'd4,  2'b01, 3'd2, 3'd3, 3'd0, 3'd0, 1'b0},  // R4 outside buffer
        '{4'd4,  2'b01, 3'd3, 3'd1, 3'd0, 3'd0, 1'b0},  // R4
        '{4'd4,  2'b10, 3'd0, 3'd0, 3'd4, 3'd2, 1'b0},  // R4 linear underflow
        '{4'd4,  2'b10, 3'd0, 3'd0, 3'd5, 3'd4, 1'b0},  // R4 single post-dec by step
        '{4'd5,  2'b01, 3'd6, 3'd5, 3'd0, 3'd0, 1'b0},  // R5
        '{4'd6,  2'b01, 3'd3, 3'd6, 3'd0, 3'd0, 1'b0},  // R6
        '{4'd7,  2'b01, 3'd3, 3'd0, 3'd0, 3'd0, 1'b0},  // R7
        '{4'd4,  2'b11, 3'd0, 3'd1, 3'd4, 3'd1, 1'b0},  // R4 dual
        '{4'd4,  2'b11, 3'd0, 3'd3, 3'd5, 3'd2, 1'b0},  // R4 dual
        '{4'd8,  2'b11, 3'd0, 3'd4, 3'd4, 3'd1, 1'b1},  // R8
        '{4'd8,  2'b11, 3'd1, 3'd1, 3'd6, 3'd5, 1'b1},  // R8
        '{4'd8,  2'b11, 3'd2, 3'd6, 3'd7, 3'd0, 1'b1},  // R8
        '{4'd9,  2'b11, 3'd0, 3'd1, 3'd2, 3'd1, 1'b1},  // R9
        '{4'd9,  2'b11, 3'd3, 3'd1, 3'd3, 3'd1, 1'b1},  // R9 same register
        '{4'd10, 2'b01, 3'd7, 3'd7, 3'd0, 3'd0, 1'b1},  // R10
        '{4'd4,  2'b10, 3'd0, 3'd0, 3'd7, 3'd1, 1'b0},  // R4 wrap to zero
        '{4'd4,  2'b10, 3'd0, 3'd0, 3'd1, 3'd1, 1'b0},  // R4 port 1 on bank 0
        '{4'd7,  2'b11, 3'd0, 3'd0, 3'd4, 3'd0, 1'b0},  // R7 dual
        '{4'd4,  2'b11, 3'd4, 3'd3, 3'd0, 3'd2, 1'b0}   // R4 crossed banks
    };

    task automatic run_vec(input vec_t v);
        string tag;
        logic [2:0]    idx [2];
        logic [2:0]    md  [2];
        logic [AW-1:0] nv  [2];
        logic [AW-1:0] got;
        tag = $sformatf("R%0d", v.rq);
        idx[0] = v.i0;  md[0] = v.md0;
        idx[1] = v.i1;  md[1] = v.md1;
        req_vld = v.vld;
        req_idx[0] = v.i0;  req_mode[0] = v.md0;
        req_idx[1] = v.i1;  req_mode[1] = v.md1;
        #1;
        chk({tag, " illegal"}, AW'(illegal), AW'(v.ill));
        for (int p = 0; p < 2; p++) begin
            nv[p] = arith(mr[idx[p]], m_ofs(md[p]) ? mn[idx[p]] : 16'd1, m_sub(md[p]), mm[idx[p]]);
            if (v.vld[p]) begin
                chk({tag, " extra_cycle"}, AW'(extra_cycle[p]), AW'(!v.ill && m_res(md[p]) && md[p] != 3'd7));
                if (!v.ill) chk({tag, " ea"}, ea[p], m_res(md[p]) ? nv[p] : mr[idx[p]]);
            end
        end
        @(posedge clk); #1;
        req_vld = '0;
        if (!v.ill) begin
            for (int p = 0; p < 2; p++)
                if (v.vld[p] && m_wb(md[p])) mr[idx[p]] = nv[p];
        end
        for (int p = 0; p < 2; p++) begin
            if (v.vld[p]) begin
                rd(2'd0, idx[p], got);
                chk({tag, " pointer after"}, got, mr[idx[p]]);
                rd(2'd1, idx[p], got);
                chk({tag, " step after"}, got, mn[idx[p]]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        for (int i = 0; i < 8; i++) begin
            mr[i] = 16'hFFFF; mn[i] = 16'hFFFF; mm[i] = 16'hFFFF;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(2'd0, 3'd0, v); chk("R1 pointer 0", v, 16'hFFFF);
        rd(2'd1, 3'd5, v); chk("R1 step 5", v, 16'hFFFF);
        rd(2'd2, 3'd7, v); chk("R1 modifier 7", v, 16'hFFFF);
        chk("R1 illegal idle", AW'(illegal), 16'd0);
        chk("R1 extra idle", AW'(extra_cycle), 16'd0);

        // R2 load and read, selector 3 writes nothing
        wr(2'd1, 3'd2, 16'hA5A5);
        rd(2'd1, 3'd2, v); chk("R2 step load", v, 16'hA5A5);
        rd(2'd0, 3'd2, v); chk("R2 pointer untouched", v, 16'hFFFF);
        wr(2'd3, 3'd2, 16'h1111);
        rd(2'd0, 3'd2, v); chk("R2 sel 3 pointer", v, 16'hFFFF);
        rd(2'd1, 3'd2, v); chk("R2 sel 3 step", v, 16'hA5A5);
        rd(2'd2, 3'd2, v); chk("R2 sel 3 modifier", v, 16'hFFFF);

        // hand-worked arithmetic cases
        preload();
        req_vld = 2'b01; req_idx[0] = 3'd0; req_mode[0] = 3'd3;
        #1;
        chk("R3 base", upd_base[0], 16'd75);
        chk("R3 step by offset", upd_step[0], 16'd15);
        chk("R3 modifier", upd_mod[0], 16'd20);
        chk("R3 add", AW'(upd_sub[0]), 16'd0);
        req_mode[0] = 3'd2; req_idx[0] = 3'd1;
        #1;
        chk("R3 step one", upd_step[0], 16'd1);
        chk("R3 sub", AW'(upd_sub[0]), 16'd1);
        chk("R3 own modifier", upd_mod[0], 16'd0);
        req_idx[0] = 3'd0; req_mode[0] = 3'd3;
        @(posedge clk); #1;
        req_vld = '0;
        rd(2'd0, 3'd0, v); chk("R4 modulo 75+15 -> 69", v, 16'd69);
        req_vld = 2'b10; req_idx[1] = 3'd1; req_mode[1] = 3'd3;
        @(posedge clk); #1;
        req_vld = '0;
        rd(2'd0, 3'd1, v); chk("R4 reverse carry 3072 -> 3584", v, 16'd3584);
        req_vld = 2'b01; req_idx[0] = 3'd2; req_mode[0] = 3'd3;
        @(posedge clk); #1;
        req_vld = '0;
        rd(2'd0, 3'd2, v); chk("R4 outside buffer 6 -> 0", v, 16'd0);

        // table walk
        preload();
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R11 load beats a pointer update of the same register
        preload();
        req_vld = 2'b01; req_idx[0] = 3'd3; req_mode[0] = 3'd1;
        wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 3'd3; wr_data = 16'h1234;
        @(posedge clk); #1;
        req_vld = '0; wr_en = 1'b0;
        rd(2'd0, 3'd3, v); chk("R11 pointer load wins", v, 16'h1234);
        // step load during a by-step update: update uses old step
        req_vld = 2'b01; req_idx[0] = 3'd5; req_mode[0] = 3'd3;
        wr_en = 1'b1; wr_sel = 2'd1; wr_idx = 3'd5; wr_data = 16'd100;
        @(posedge clk); #1;
        req_vld = '0; wr_en = 1'b0;
        rd(2'd0, 3'd5, v); chk("R11 update used old step", v, 16'h7709);
        rd(2'd1, 3'd5, v); chk("R11 step loaded", v, 16'd100);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule